// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 20-bit byte virtual address into a 19-bit physical address. It walks a two-level translation structure. The eight first-level entries sit in a small register array inside the block, and software fills that array through a write port. Each second-level table occupies an ordinary physical page. The block fetches the second-level entry it needs over a read port: the request uses a valid/ready handshake, and the 32-bit big-endian line comes back on a separate valid strobe.

A caller presents one virtual address at a time. The block selects a first-level entry with the top three address bits. If that entry is resident, the block builds the byte address of the second-level entry from the entry's frame number and the middle eight address bits, and reads it. If the second-level entry is resident, its frame number is joined to the untouched 9-bit page offset. A clear resident flag at either level ends the walk with a fault that reports which level failed. The result is held until the caller acknowledges it.

Top module: `pt_walker`

## Requirements
- R1: A successful walk returns `{second-level frame[9:0], vaddr[8:0]}` with `rsp_fault` = 0.
- R2: The first-level entry is chosen by vaddr[19:17] from the array written by `l1_we`/`l1_widx`/`l1_wdata`. After reset, every array entry is zero, which means not resident.
- R3: The second-level read uses byte address `{first-level frame[9:0], vaddr[16:9], 1'b0}`.
- R4: The returned line is big-endian. If the entry address bit 1 is 0, the entry is `mem_rdata[31:16]`. If it is 1, the entry is `mem_rdata[15:0]`.
- R5: If bit 15 of the first-level entry is 0, the block issues no memory read and returns `rsp_fault` = 1, `rsp_fault_lvl` = 0 and `rsp_paddr` = 0.
- R6: If bit 15 of the second-level entry is 0, the block returns `rsp_fault` = 1, `rsp_fault_lvl` = 1 and `rsp_paddr` = 0.
- R7: Bits 14:10 of an entry at either level have no effect on the result.
- R8: `req_ready` is high only while no walk is in progress. The response fields stay valid and unchanged until `rsp_ready` is sampled high.
- R9: A raised memory read request keeps its address unchanged until `mem_rd_ready` is sampled high.
- R10: After reset, `req_ready` = 1, `rsp_valid` = 0 and `mem_rd_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1_we | input | 1 | First-level array write strobe |
| l1_widx | input | 3 | First-level entry index to write |
| l1_wdata | input | 16 | First-level entry value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_vaddr | input | 20 | Virtual byte address |
| mem_rd_valid | output | 1 | Second-level entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 19 | Byte address of the second-level entry |
| mem_rvalid | input | 1 | Read line returned |
| mem_rdata | input | 32 | Returned 4-byte line, byte 0 most significant |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Caller takes the result |
| rsp_paddr | output | 19 | Physical byte address, zero on fault |
| rsp_fault | output | 1 | Walk ended at a non-resident entry |
| rsp_fault_lvl | output | 1 | Failing level: 0 first, 1 second |

## Verification
The hardest case to reach from the ports is a second-level fault on an entry taken from the upper half of a line whose lower half is resident. Both halves have to come from the same line, and the first-level entry must point at that line. The bench provides this with a memory model that can pin one chosen line to a fixed value. Directed walks with odd and even second-level indices then read both halves of that line, and some of those walks also set the ignored entry bits. Random walks over a hashed memory image, with re-written first-level entries, memory stalls and delayed acknowledges, mix resident and non-resident entries at both levels.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W   = 20,
  parameter int L1_W   = 3,
  parameter int OFF_W  = 9,
  parameter int PFN_W  = 10,
  parameter int ENT_W  = 16,
  parameter int LINE_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          l1_we,
  input  logic [L1_W-1:0]               l1_widx,
  input  logic [ENT_W-1:0]              l1_wdata,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [VA_W-1:0]               req_vaddr,
  output logic                          mem_rd_valid,
  input  logic                          mem_rd_ready,
  output logic [PFN_W+VA_W-L1_W-OFF_W:0] mem_rd_addr,
  input  logic                          mem_rvalid,
  input  logic [LINE_W-1:0]             mem_rdata,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [PFN_W+OFF_W-1:0]        rsp_paddr,
  output logic                          rsp_fault,
  output logic                          rsp_fault_lvl
);
  localparam int L2_W  = VA_W - L1_W - OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int EA_W  = PFN_W + L2_W + 1;
  localparam int L1_N  = 1 << L1_W;
  localparam int RES_B = ENT_W - 1;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_RSP} state_t;

  state_t            state;
  logic [ENT_W-1:0]  l1_tab [L1_N];
  logic [OFF_W-1:0]  off_q;
  logic [EA_W-1:0]   ea_q;
  logic [PA_W-1:0]   paddr_q;
  logic              fault_q, lvl_q;
  logic [ENT_W-1:0]  l1_ent, l2_ent;
  logic              unused_bits;

  assign l1_ent = l1_tab[req_vaddr[VA_W-1 -: L1_W]];
  assign l2_ent = ea_q[1] ? mem_rdata[ENT_W-1:0] : mem_rdata[LINE_W-1 -: ENT_W];
  assign unused_bits = ^{l1_ent[RES_B-1:PFN_W], l2_ent[RES_B-1:PFN_W]};

  assign req_ready     = (state == S_IDLE);
  assign mem_rd_valid  = (state == S_RD);
  assign mem_rd_addr   = ea_q;
  assign rsp_valid     = (state == S_RSP);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign rsp_fault_lvl = lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < L1_N; i++) l1_tab[i] <= '0;
    end else if (l1_we) begin
      l1_tab[l1_widx] <= l1_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      off_q   <= '0;
      ea_q    <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          off_q <= req_vaddr[OFF_W-1:0];
          ea_q  <= {l1_ent[PFN_W-1:0], req_vaddr[OFF_W +: L2_W], 1'b0};
          if (l1_ent[RES_B]) begin
            state <= S_RD;
          end else begin
            paddr_q <= '0;
            fault_q <= 1'b1;
            lvl_q   <= 1'b0;
            state   <= S_RSP;
          end
        end
        S_RD: if (mem_rd_ready) state <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          lvl_q <= 1'b1;
          if (l2_ent[RES_B]) begin
            paddr_q <= {l2_ent[PFN_W-1:0], off_q};
            fault_q <= 1'b0;
          end else begin
            paddr_q <= '0;
            fault_q <= 1'b1;
          end
          state <= S_RSP;
        end
        S_RSP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W  = 20,
  parameter int L1_W  = 3,
  parameter int OFF_W = 9,
  parameter int PFN_W = 10
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic [VA_W-1:0]               req_vaddr,
  input logic                          mem_rd_valid,
  input logic                          mem_rd_ready,
  input logic [PFN_W+VA_W-L1_W-OFF_W:0] mem_rd_addr,
  input logic                          rsp_valid,
  input logic                          rsp_ready,
  input logic [PFN_W+OFF_W-1:0]        rsp_paddr,
  input logic                          rsp_fault,
  input logic                          rsp_fault_lvl
);
  localparam int L2_W = VA_W - L1_W - OFF_W;

  logic [OFF_W-1:0] off_cap;
  logic [L2_W-1:0]  l2_cap;
  logic             rd_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_cap <= '0;
      l2_cap  <= '0;
      rd_seen <= 1'b0;
    end else if (req_valid && req_ready) begin
      off_cap <= req_vaddr[OFF_W-1:0];
      l2_cap  <= req_vaddr[OFF_W +: L2_W];
      rd_seen <= 1'b0;
    end else if (mem_rd_valid && mem_rd_ready) begin
      rd_seen <= 1'b1;
    end
  end

  a_r10_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> (req_ready && !rsp_valid && !mem_rd_valid));

  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_rd_valid) |-> !req_ready);

  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                   && $stable(rsp_fault) && $stable(rsp_fault_lvl)));

  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  a_r3_entry_index: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (mem_rd_addr[L2_W:1] == l2_cap && !mem_rd_addr[0]));

  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == off_cap));

  a_r5_no_read_on_l1_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && !rsp_fault_lvl) |-> !rd_seen);

  a_r6_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
endmodule

bind pt_walker pt_walker_chk #(
  .VA_W(VA_W), .L1_W(L1_W), .OFF_W(OFF_W), .PFN_W(PFN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr(mem_rd_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        l1_we = 1'b0;
  logic [2:0]  l1_widx = '0;
  logic [15:0] l1_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vaddr = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [18:0] mem_rd_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [18:0] rsp_paddr;
  logic        rsp_fault;
  logic        rsp_fault_lvl;

  always #4 clk = ~clk;

  pt_walker u_dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  int rd_cnt = 0;
  logic [18:0] last_rd_addr = '0;
  logic [15:0] bl1 [8];
  logic        ovr_en = 1'b0;
  logic [16:0] ovr_line = '0;
  logic [31:0] ovr_data = '0;

  function automatic logic [31:0] mem_line(input logic [16:0] la);
    logic [31:0] h;
    if (ovr_en && la == ovr_line) return ovr_data;
    h = {15'd0, la} * 32'h9E37_79B1;
    return h ^ {h[15:0], h[31:16]} ^ 32'h5A5A_1234;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_l1(input logic [2:0] idx, input logic [15:0] d);
    @(negedge clk);
    l1_we = 1'b1; l1_widx = idx; l1_wdata = d;
    @(negedge clk);
    l1_we = 1'b0;
    bl1[idx] = d;
  endtask

  // memory model: decisions and drives happen at negative edges
  initial begin
    int delay;
    bit pend;
    logic [18:0] a;
    pend = 1'b0; delay = 0; a = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (pend) begin
        if (delay == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem_line(a[18:2]);
          pend = 1'b0;
        end else delay--;
      end
      mem_rd_ready = ($urandom % 3) != 0;
      if (mem_rd_valid && mem_rd_ready) begin
        a = mem_rd_addr; last_rd_addr = mem_rd_addr; rd_cnt++;
        pend = 1'b1; delay = $urandom % 3;
      end
    end
  end

  task automatic walk(input logic [19:0] va, input int hold);
    logic [15:0] e1, e2;
    logic [18:0] ea, exp_pa;
    logic [31:0] ln;
    bit exp_f, exp_l, exp_rd, busy_bad;
    int rd0;
    e1 = bl1[va[19:17]];
    ea = {e1[9:0], va[16:9], 1'b0};
    exp_rd = e1[15];
    exp_pa = '0; exp_f = 1'b1; exp_l = 1'b0;
    if (e1[15]) begin
      ln = mem_line(ea[18:2]);
      e2 = ea[1] ? ln[15:0] : ln[31:16];
      exp_l = 1'b1;
      if (e2[15]) begin exp_f = 1'b0; exp_pa = {e2[9:0], va[8:0]}; end
    end
    rd0 = rd_cnt;
    @(negedge clk);
    check(req_ready, "R8 idle ready", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    busy_bad = 1'b0;
    while (!rsp_valid) begin
      if (req_ready) busy_bad = 1'b1;
      @(negedge clk);
    end
    check(!busy_bad, "R8 no accept while busy", {31'd0, busy_bad}, 32'd0);
    check(rsp_fault == exp_f && rsp_fault_lvl == exp_l,
          exp_f ? (exp_l ? "R6 level-2 fault" : "R5 level-1 fault") : "R1 fault flags",
          {30'd0, rsp_fault, rsp_fault_lvl}, {30'd0, exp_f, exp_l});
    check(rsp_paddr == exp_pa, exp_f ? "R6 fault paddr zero" : "R1 paddr",
          {13'd0, rsp_paddr}, {13'd0, exp_pa});
    if (exp_rd) begin
      check(rd_cnt == rd0 + 1 && last_rd_addr == ea, "R3 entry address",
            {13'd0, last_rd_addr}, {13'd0, ea});
    end else begin
      check(rd_cnt == rd0, "R5 no memory read", rd_cnt - rd0, 32'd0);
    end
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(rsp_valid && rsp_paddr == exp_pa, "R8 response held",
            {12'd0, rsp_valid, rsp_paddr}, {12'd1, exp_pa});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid && req_ready, "R8 return to idle",
          {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 8; i++) bl1[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_rd_valid, "R10 reset state",
          {29'd0, req_ready, rsp_valid, mem_rd_valid}, 32'd4);

    // R2: cleared array faults at level 1 for every index
    for (int i = 0; i < 8; i++) walk({i[2:0], 17'h0A5A5}, 0);

    // R1/R3/R4: worked example, low half of line
    ovr_en = 1'b1; ovr_line = 17'h1B8E3; ovr_data = 32'h1F3E_B0D9;
    wr_l1(3'd5, 16'hAF71);
    walk(20'hB8ED1, 2);
    // explicit R1 value: 0xB8ED1 -> 0x1B2D1
    walk(20'hB8ED1, 0);
    // R4/R6: upper half 0x1F3E not resident
    walk(20'hB8CD1, 1);
    // R4: upper half resident
    ovr_data = 32'h9F3E_B0D9;
    walk(20'hB8CD1, 0);
    // R7: ignored bits set at both levels, same result
    wr_l1(3'd5, 16'hFF71);
    ovr_data = 32'h9F3E_FCD9;
    walk(20'hB8ED1, 0);
    check(1'b1, "R7 covered by preceding walk", 32'd0, 32'd0);
    // R5: non-resident first level with garbage frame bits
    wr_l1(3'd2, 16'h7FFF);
    walk(20'h41234, 1);
    ovr_en = 1'b0;

    for (int n = 0; n < 400; n++) begin
      if ($urandom % 4 == 0) wr_l1(3'($urandom), 16'($urandom));
      walk(20'($urandom), $urandom % 3);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // direct check of the worked example on every response to 0xB8ED1 with the pinned line
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid && req_vaddr == 20'hB8ED1 && ovr_en && ovr_data == 32'h1F3E_B0D9
          && bl1[5] == 16'hAF71 && !rsp_ready) begin
        check(rsp_paddr == 19'h1B2D1 && !rsp_fault, "R1 example 0xB8ED1",
              {13'd0, rsp_paddr}, 32'h1B2D1);
        while (rsp_valid) @(negedge clk);
      end
    end
  end
endmodule